// File: doc/BRIEF.md
# Prefix-Driven Effective Address Generator

This block works out the effective operand address of one instruction. The caller gives it two 4-bit mode codes, one from the base mode table and one from the alternate table. It also gives a prefix byte, an extension prefix byte, the X, Y and E index registers, and the address of the first byte after the opcode (`pc_i`). The extension prefix picks which of the two mode codes applies. Bits of the prefix byte pick how many address bytes follow the opcode. The block then fetches those bytes, and any 8-byte indirect pointer, through a byte-wide valid/ready read port. It returns the effective address, the number of bytes the program counter must skip, and the encoded address size.

Mode codes (shared by both tables):

| Code | Mode |
|------|------|
| 0 | none |
| 1 | immediate |
| 2 | zero-matrix (ZM) |
| 3 | ZM + X |
| 4 | ZM + Y |
| 5 | ZM indirect |
| 6 | ZM pre-X indirect |
| 7 | ZM indirect post-Y |
| 8 | absolute |
| 9 | absolute + X |
| 10 | absolute + Y |
| 11 | absolute indirect |
| 12 | absolute pre-X indirect |
| 13 | absolute indirect post-Y |
| 14 | E-indirect |
| 15 | none |

A request is a one-cycle `start_i` while `busy_o` is low. The result is valid in the cycle where `done_o` pulses, and it holds until the next request.

Top module: `eag_top`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `rd_valid_o` are 0, `ea_o` is 0, `pc_adv_o` is 0 and `size_code_o` is 0xFF.
- R2: The alternate mode code is used when (`ext_prefix_i` & 0x0D) == 0x0D and `ext_prefix_i`[7:4] == 0. In every other case the base mode code is used.
- R3: For the ZM modes (codes 2..7), with s = `prefix_i`[3:2]: s=0 gives size code 0, s=1 gives 2, s=2 gives 5 and s=3 gives 3. Exactly size+1 operand bytes are read, and `pc_adv_o` = size+1.
- R4: For the absolute modes (codes 8..13): s=0 gives size code 1, s=1 gives 4, s=2 gives 6 and s=3 gives 7. The read count and `pc_adv_o` follow the same rule as in R3.
- R5: Operand bytes are read from `pc_i`, `pc_i`+1, ... and are assembled little-endian: byte i is placed at bits [8i+7:8i].
- R6: The indexed modes (3, 4, 9, 10) add X (codes 3, 9) or Y (codes 4, 10) to the assembled base address, modulo 2^AW.
- R7: The pre-X indirect modes (6, 12) read an 8-byte little-endian pointer starting at base+X. The effective address is that pointer.
- R8: The plain indirect modes (5, 11) read the 8-byte pointer at the base. The post-Y modes (7, 13) read the 8-byte pointer at the base and add Y to it.
- R9: E-indirect (code 14) takes effect only from the alternate table. It gives `ea_o` = E, no reads, `pc_adv_o` = 0 and size code 0xFF. Code 14 taken from the base table behaves like code 0.
- R10: Immediate mode gives `ea_o` = `pc_i`, no reads and size code 0xFF. `pc_adv_o` is 1 << `prefix_i`[5:4], except that it is 1 when `shift_imm_i` is set and the base table is in use.
- R11: Codes 0 and 15 give `ea_o` = 0, `pc_adv_o` = 0, size code 0xFF and no reads.
- R12: `done_o` is a one-cycle pulse. For modes that read nothing it comes in the cycle after acceptance. For modes that read, it comes in the cycle after the final read beat, when `busy_o` falls. While `busy_o` is high, `start_i` and every other request input are ignored.
- R13: Once `rd_valid_o` is raised, it stays high with `rd_addr_o` unchanged until `rd_ready_i` accepts the beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| mode_base_i | input | 4 | Mode code from the base table |
| mode_alt_i | input | 4 | Mode code from the alternate table |
| shift_imm_i | input | 1 | The opcode is a shift/rotate immediate |
| prefix_i | input | 8 | Prefix byte; [3:2] address size, [5:4] immediate size |
| ext_prefix_i | input | 8 | Extension prefix byte; selects the table |
| x_i | input | AW | X index register |
| y_i | input | AW | Y index register |
| e_i | input | AW | E register |
| pc_i | input | AW | Address of the first byte after the opcode |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | AW | Read byte address |
| rd_ready_i | input | 1 | Read beat accepted, `rd_data_i` valid |
| rd_data_i | input | 8 | Read data byte |
| busy_o | output | 1 | Reads in progress |
| done_o | output | 1 | One-cycle result strobe |
| ea_o | output | AW | Effective address |
| pc_adv_o | output | 4 | Bytes for the program counter to skip |
| size_code_o | output | 8 | Encoded address size, or 0xFF |

## Verification
The assertions check, on every cycle, the properties that can be seen from the port signals alone:
- read requests hold while stalled, with the address unchanged;
- `done_o` is a single pulse, and it coincides with the end of `busy_o`;
- size codes are legal, and agree with the PC advance;
- the latched results stay frozen while a busy period ignores `start_i`.

Only the bench can show that the numbers themselves are right. This covers:
- the table choice made by the extension prefix;
- the per-family size tables;
- little-endian assembly;
- where the X and Y indexes are added relative to the pointer read;
- the immediate and E-indirect results.

The bench sweeps every mode code against every size selector and both tables, with random read-port stalls and with address wrap-around.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam logic [3:0] MD_NONE  = 4'd0;
  localparam logic [3:0] MD_IMM   = 4'd1;
  localparam logic [3:0] MD_ZFIRST = 4'd2;
  localparam logic [3:0] MD_AFIRST = 4'd8;
  localparam logic [3:0] MD_EIND  = 4'd14;

  // index/indirection flavour inside a family (offset from family start)
  localparam logic [2:0] SUB_PLAIN = 3'd0;
  localparam logic [2:0] SUB_ADDX  = 3'd1;
  localparam logic [2:0] SUB_ADDY  = 3'd2;
  localparam logic [2:0] SUB_IND   = 3'd3;
  localparam logic [2:0] SUB_PREX  = 3'd4;
  localparam logic [2:0] SUB_POSTY = 3'd5;

  localparam logic [7:0] SIZE_NONE = 8'hFF;

  typedef struct packed {
    logic reads;
    logic ind;
    logic pre;
    logic post;
    logic use_x;
    logic use_y;
    logic imm;
    logic eind;
  } mode_info_t;

  function automatic logic alt_table(input logic [7:0] ext);
    return ((ext & 8'h0D) == 8'h0D) && (ext[7:4] == 4'h0);
  endfunction

endpackage

// File: rtl/eag_mode_dec.sv
module eag_mode_dec
  import eag_pkg::*;
#(
  parameter int ADVW = 4
) (
  input  logic [3:0]      mode_base_i,
  input  logic [3:0]      mode_alt_i,
  input  logic [7:0]      prefix_i,
  input  logic [7:0]      ext_prefix_i,
  input  logic            shift_imm_i,
  output mode_info_t      info_o,
  output logic [7:0]      size_code_o,
  output logic [ADVW-1:0] pc_adv_o
);

  logic       use_alt;
  logic [3:0] mode;
  logic       zfam;
  logic       afam;
  logic [2:0] sub;
  logic [1:0] asel;
  logic [1:0] isel;

  assign use_alt = alt_table(ext_prefix_i);
  assign asel    = prefix_i[3:2];
  assign isel    = prefix_i[5:4];

  always_comb begin
    mode = use_alt ? mode_alt_i : mode_base_i;
    if (!use_alt && (mode == MD_EIND)) mode = MD_NONE;
    zfam = (mode >= MD_ZFIRST) && (mode < MD_AFIRST);
    afam = (mode >= MD_AFIRST) && (mode < MD_EIND);
    sub  = '0;
    if (zfam) sub = 3'(mode - MD_ZFIRST);
    if (afam) sub = 3'(mode - MD_AFIRST);

    info_o        = '0;
    info_o.reads  = zfam || afam;
    info_o.ind    = (zfam || afam) && (sub >= SUB_IND);
    info_o.pre    = (zfam || afam) && (sub == SUB_PREX);
    info_o.post   = (zfam || afam) && (sub == SUB_POSTY);
    info_o.use_x  = (zfam || afam) && ((sub == SUB_ADDX) || (sub == SUB_PREX));
    info_o.use_y  = (zfam || afam) && ((sub == SUB_ADDY) || (sub == SUB_POSTY));
    info_o.imm    = (mode == MD_IMM);
    info_o.eind   = (mode == MD_EIND);

    size_code_o = SIZE_NONE;
    if (zfam) begin
      unique case (asel)
        2'd0: size_code_o = 8'd0;
        2'd1: size_code_o = 8'd2;
        2'd2: size_code_o = 8'd5;
        default: size_code_o = 8'd3;
      endcase
    end else if (afam) begin
      unique case (asel)
        2'd0: size_code_o = 8'd1;
        2'd1: size_code_o = 8'd4;
        2'd2: size_code_o = 8'd6;
        default: size_code_o = 8'd7;
      endcase
    end

    pc_adv_o = '0;
    if (zfam || afam) begin
      pc_adv_o = ADVW'(size_code_o[2:0]) + ADVW'(1);
    end else if (info_o.imm) begin
      if (shift_imm_i && !use_alt) pc_adv_o = ADVW'(1);
      else                         pc_adv_o = ADVW'(1) << isel;
    end
  end

endmodule

// File: rtl/eag_byte_collect.sv
module eag_byte_collect #(
  parameter int AW = 64,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          take_i,
  input  logic [7:0]    data_i,
  input  logic [CW-1:0] last_idx_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic [AW-1:0] word_o
);

  logic [AW-1:0] acc_q, acc_nx;
  logic [CW-1:0] cnt_q, cnt_nx;

  assign word_o = acc_q | (AW'(data_i) << {cnt_q, 3'b000});
  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == last_idx_i);

  always_comb begin
    acc_nx = acc_q;
    cnt_nx = cnt_q;
    if (clr_i) begin
      acc_nx = '0;
      cnt_nx = '0;
    end else if (take_i) begin
      acc_nx = word_o;
      cnt_nx = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_nx;
      cnt_q <= cnt_nx;
    end
  end

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [3:0]    mode_base_i,
  input  logic [3:0]    mode_alt_i,
  input  logic          shift_imm_i,
  input  logic [7:0]    prefix_i,
  input  logic [7:0]    ext_prefix_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] e_i,
  input  logic [AW-1:0] pc_i,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ready_i,
  input  logic [7:0]    rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic [3:0]    pc_adv_o,
  output logic [7:0]    size_code_o
);

  localparam int PTR_BYTES = AW / 8;
  localparam int CW        = (PTR_BYTES > 1) ? $clog2(PTR_BYTES) : 1;
  localparam logic [CW-1:0] PTR_LAST = CW'(PTR_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OPND, ST_PTR} state_e;

  state_e        st_q, st_nx;
  mode_info_t    info_q, info_nx, dec_info;
  logic [AW-1:0] base_q, base_nx;
  logic [AW-1:0] idx_q, idx_nx;
  logic [AW-1:0] ea_q, ea_nx;
  logic [7:0]    size_q, size_nx, dec_size;
  logic [3:0]    adv_q, adv_nx, dec_adv;
  logic          done_q, done_nx;

  logic          clr;
  logic          beat;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;
  logic          last;
  logic [AW-1:0] word;

  eag_mode_dec #(.ADVW(4)) dec_i (
    .mode_base_i  (mode_base_i),
    .mode_alt_i   (mode_alt_i),
    .prefix_i     (prefix_i),
    .ext_prefix_i (ext_prefix_i),
    .shift_imm_i  (shift_imm_i),
    .info_o       (dec_info),
    .size_code_o  (dec_size),
    .pc_adv_o     (dec_adv)
  );

  assign busy_o     = (st_q != ST_IDLE);
  assign rd_valid_o = busy_o;
  assign rd_addr_o  = base_q + AW'(cnt);
  assign beat       = rd_valid_o && rd_ready_i;
  assign last_idx   = (st_q == ST_PTR) ? PTR_LAST : size_q[CW-1:0];

  eag_byte_collect #(.AW(AW), .CW(CW)) col_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .take_i     (beat),
    .data_i     (rd_data_i),
    .last_idx_i (last_idx),
    .cnt_o      (cnt),
    .last_o     (last),
    .word_o     (word)
  );

  always_comb begin
    st_nx   = st_q;
    info_nx = info_q;
    base_nx = base_q;
    idx_nx  = idx_q;
    ea_nx   = ea_q;
    size_nx = size_q;
    adv_nx  = adv_q;
    done_nx = 1'b0;
    clr     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          clr     = 1'b1;
          info_nx = dec_info;
          size_nx = dec_size;
          adv_nx  = dec_adv;
          base_nx = pc_i;
          idx_nx  = dec_info.use_x ? x_i : (dec_info.use_y ? y_i : '0);
          if (dec_info.reads) begin
            st_nx = ST_OPND;
          end else begin
            done_nx = 1'b1;
            ea_nx   = dec_info.imm ? pc_i : (dec_info.eind ? e_i : '0);
          end
        end
      end
      ST_OPND: begin
        if (beat && last) begin
          clr = 1'b1;
          if (info_q.ind) begin
            base_nx = word + (info_q.pre ? idx_q : '0);
            st_nx   = ST_PTR;
          end else begin
            ea_nx   = word + idx_q;
            done_nx = 1'b1;
            st_nx   = ST_IDLE;
          end
        end
      end
      ST_PTR: begin
        if (beat && last) begin
          clr     = 1'b1;
          ea_nx   = word + (info_q.post ? idx_q : '0);
          done_nx = 1'b1;
          st_nx   = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      info_q <= '0;
      base_q <= '0;
      idx_q  <= '0;
      ea_q   <= '0;
      size_q <= SIZE_NONE;
      adv_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      info_q <= info_nx;
      base_q <= base_nx;
      idx_q  <= idx_nx;
      ea_q   <= ea_nx;
      size_q <= size_nx;
      adv_q  <= adv_nx;
      done_q <= done_nx;
    end
  end

  assign done_o      = done_q;
  assign ea_o        = ea_q;
  assign pc_adv_o    = adv_q;
  assign size_code_o = size_q;

endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rd_valid_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ready_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [3:0]    pc_adv_o,
  input logic [7:0]    size_code_o
);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R13

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12

  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R12

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(size_code_o) && $stable(pc_adv_o)); // R12

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (size_code_o <= 8'd7) || (size_code_o == 8'hFF)); // R4

  AST_ADV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (size_code_o != 8'hFF) |-> pc_adv_o == size_code_o[3:0] + 4'd1); // R3

endmodule

bind eag_top eag_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .rd_valid_o  (rd_valid_o),
  .rd_addr_o   (rd_addr_o),
  .rd_ready_i  (rd_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pc_adv_o    (pc_adv_o),
  .size_code_o (size_code_o)
);

// File: tb/eag_top_tb.sv
module eag_top_tb_top;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    mode_base_i = '0, mode_alt_i = '0;
  logic          shift_imm_i = 1'b0;
  logic [7:0]    prefix_i = '0, ext_prefix_i = '0;
  logic [AW-1:0] x_i = '0, y_i = '0, e_i = '0, pc_i = '0;
  logic          rd_valid_o, rd_ready_i = 1'b0;
  logic [AW-1:0] rd_addr_o;
  logic [7:0]    rd_data_i;
  logic          busy_o, done_o;
  logic [AW-1:0] ea_o;
  logic [3:0]    pc_adv_o;
  logic [7:0]    size_code_o;

  int total = 0, bad = 0, beats = 0, hold_viol = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic stall_free = 1'b0;
  logic prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  eag_top #(.AW(AW)) dut_i (.*);

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return a[7:0] * 8'd13 + a[15:8] + 8'h29;
  endfunction

  assign rd_data_i = mb(rd_addr_o);

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready_i <= stall_free | lfsr[0] | lfsr[3];
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall && (!rd_valid_o || rd_addr_o != prev_addr)) hold_viol++;
      if (rd_valid_o && rd_ready_i) beats++;
      prev_stall = rd_valid_o && !rd_ready_i;
      prev_addr  = rd_addr_o;
    end
  end

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] rd_le(input logic [AW-1:0] a, input int n);
    logic [AW-1:0] v = '0;
    for (int i = 0; i < n; i++) v |= AW'(mb(a + AW'(i))) << (8 * i);
    return v;
  endfunction

  // model from the requirements
  task automatic model(input logic [3:0] mbase, input logic [3:0] malt, input logic shf,
                       input logic [7:0] pf, input logic [7:0] ext,
                       input logic [AW-1:0] x, input logic [AW-1:0] y,
                       input logic [AW-1:0] e, input logic [AW-1:0] pc,
                       output logic [AW-1:0] ea, output logic [3:0] adv,
                       output logic [7:0] sz, output int nbeats, output string req);
    logic alt = ((ext & 8'h0D) == 8'h0D) && (ext[7:4] == 4'h0);
    int m = alt ? int'(malt) : int'(mbase);
    int s = int'(pf[3:2]);
    int sub;
    logic [AW-1:0] w;
    if (!alt && m == 14) m = 0;
    ea = '0; adv = '0; sz = 8'hFF; nbeats = 0; req = "R11";
    if (m == 1) begin
      req = "R10"; ea = pc;
      adv = (shf && !alt) ? 4'd1 : (4'd1 << pf[5:4]);
    end else if (m == 14) begin
      req = "R9"; ea = e;
    end else if (m >= 2 && m <= 13) begin
      if (m < 8) begin
        sub = m - 2; req = "R3";
        sz = (s == 0) ? 8'd0 : (s == 1) ? 8'd2 : (s == 2) ? 8'd5 : 8'd3;
      end else begin
        sub = m - 8; req = "R4";
        sz = (s == 0) ? 8'd1 : (s == 1) ? 8'd4 : (s == 2) ? 8'd6 : 8'd7;
      end
      adv = 4'(sz + 1);
      nbeats = int'(sz) + 1;
      w = rd_le(pc, nbeats);
      case (sub)
        0: ea = w;
        1: begin ea = w + x; req = "R6"; end
        2: begin ea = w + y; req = "R6"; end
        3: begin ea = rd_le(w, 8); req = "R8"; end
        4: begin ea = rd_le(w + x, 8); req = "R7"; end
        default: begin ea = rd_le(w, 8) + y; req = "R8"; end
      endcase
      if (sub >= 3) nbeats += 8;
    end
    if (alt != (mbase == malt ? alt : alt)) req = "R2";
  endtask

  task automatic run(input logic [3:0] mbase, input logic [3:0] malt, input logic shf,
                     input logic [7:0] pf, input logic [7:0] ext,
                     input logic [AW-1:0] x, input logic [AW-1:0] y,
                     input logic [AW-1:0] e, input logic [AW-1:0] pc,
                     input int disturb);
    logic [AW-1:0] xea; logic [3:0] xadv; logic [7:0] xsz; int xb; string rq;
    int t = 0;
    model(mbase, malt, shf, pf, ext, x, y, e, pc, xea, xadv, xsz, xb, rq);
    @(negedge clk);
    mode_base_i = mbase; mode_alt_i = malt; shift_imm_i = shf; prefix_i = pf;
    ext_prefix_i = ext; x_i = x; y_i = y; e_i = e; pc_i = pc;
    start_i = 1'b1; beats = 0;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb > 0) begin
      total++;
      if (!busy_o) begin bad++; $display("FAIL R12 busy actual=0 expected=1"); end
      start_i = 1'b1; mode_base_i = 4'd1; mode_alt_i = 4'd1;
      x_i = ~x; y_i = ~y; pc_i = ~pc; prefix_i = ~pf;
      repeat (disturb) @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && t < 400) begin @(negedge clk); t++; end
    total++;
    if (!done_o) begin bad++; $display("FAIL R12 done actual=0 expected=1"); end
    chk({rq, " ea"}, ea_o, xea);
    chk({rq, " pc_adv"}, AW'(pc_adv_o), AW'(xadv));
    chk({rq, " size"}, AW'(size_code_o), AW'(xsz));
    chk({rq, " beats"}, AW'(beats), AW'(xb));
    @(negedge clk);
    chk("R12 single pulse", AW'(done_o), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", AW'(busy_o), '0);
    chk("R1 done", AW'(done_o), '0);
    chk("R1 rd_valid", AW'(rd_valid_o), '0);
    chk("R1 size", AW'(size_code_o), AW'(8'hFF));
    chk("R1 ea", ea_o, '0);
    rst_n = 1'b1;
    // sweep: mode x selector x table x data set (R2..R11, R5)
    for (int d = 0; d < 3; d++) begin
      for (int m = 0; m < 16; m++) begin
        for (int s = 0; s < 4; s++) begin
          for (int tb = 0; tb < 2; tb++) begin
            logic [7:0] ext = tb ? ((s & 1) ? 8'h0F : 8'h0D)
                                 : ((s == 0) ? 8'h00 : (s == 1) ? 8'h1D : (s == 2) ? 8'h0C : 8'h2F);
            logic [3:0] other = 4'((m + 5) & 15);
            logic [7:0] pf = {2'b00, 2'((s + d + m) & 3), 2'(s), 2'b01};
            logic [AW-1:0] pc = (d == 0) ? 64'h0000_0000_0000_1000 :
                                (d == 1) ? 64'hFFFF_FFFF_FFFF_FFFC : 64'h1234_5678_9ABC_DE00;
            logic [AW-1:0] x = (d == 1) ? '1 : AW'(64'h17 + d);
            logic [AW-1:0] y = (d == 2) ? 64'h8000_0000_0000_0000 : AW'(64'h230 * (d + 1));
            stall_free = (d == 2);
            run(tb ? other : 4'(m), tb ? 4'(m) : other, 1'(m + d), pf, ext,
                x, y, 64'hE0E0_0000_0000_1234 + AW'(d), pc, 0);
          end
        end
      end
    end
    // R12: start and inputs ignored while busy (abs post-Y, full size)
    stall_free = 1'b0;
    run(4'd13, 4'd2, 1'b0, 8'h0C, 8'h00, 64'h5, 64'h99, 64'h0, 64'h4000, 5);
    run(4'd3, 4'd12, 1'b0, 8'h08, 8'h0D, 64'h40, 64'h7, 64'h0, 64'h800, 3);
    // R13 hold under stalls (aggregate over the whole run)
    chk("R13 stall hold violations", AW'(hold_viol), '0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule